// File: doc/BRIEF.md
# Release-Consistency Fence Ordering Unit

This unit sits between a processor and its second-level cache and bus interface and holds processor requests back when one-sided ordering rules demand it. It keeps two saturating counters, one of writes that are issued but not yet fully acknowledged (invalidation acknowledgements included), and one of loads in flight. The processor presents one request at a time, tagged with its kind. The unit answers with a single `stall` line. A request moves on in the cycle where `req_valid` is high and `stall` is low. While `stall` is high, the processor keeps `req_valid` and `req_kind` unchanged.

A write fence is held until no write is outstanding. A full fence is held until neither writes nor loads are outstanding. An acquire is accepted at once, and every request after it is held until the acquire-complete pulse arrives. Accesses made before the acquire never wait for it. A release is accepted at once and later accesses may proceed. The unit takes a snapshot of the counters at that moment and pulses `rel_done` once the accesses counted in the snapshot have retired. Acknowledgements are assumed to retire in issue order within each counter. Only one release can be pending at a time.

Top module: `fence_order_unit`

## Requirements
- R1: A `wr_issue` pulse raises the write count by one and a `wr_ack` pulse lowers it by one. After n issues, a write fence is released by exactly the n-th acknowledgement.
- R2: An issue and an acknowledge for the same counter in the same cycle leave it unchanged and raise no error, even at zero or at full scale.
- R3: At full scale (all ones in CNT_W bits) a further issue keeps the count at full scale. The matching error output is high for the one cycle after that clock edge.
- R4: An acknowledge at zero keeps the count at zero and pulses the matching error output for one cycle.
- R5: A write fence (kind code 4) stalls while the write count is non-zero and is accepted when it is zero. Outstanding loads do not affect it.
- R6: A full fence (kind code 5) stalls while either the write count or the load count is non-zero.
- R7: Once an acquire (kind code 2) is accepted, every request stalls until an `acq_done` pulse, and it stops stalling in the cycle after that pulse. An `acq_done` with no acquire pending has no effect.
- R8: Loads (code 0) and stores (code 1) are never stalled by outstanding writes or loads. Only a pending acquire holds them.
- R9: A release (code 3) is accepted without stalling. `rel_done` goes high for exactly one cycle once the writes and loads outstanding at acceptance have retired, independent of accesses issued later. With nothing outstanding it goes high in the cycle right after acceptance.
- R10: A release presented while an earlier release is still pending stalls.
- R11: After reset, both counts are zero, no acquire or release is pending, `stall`, `rel_done` and both error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_kind | input | 3 | 0 load, 1 store, 2 acquire, 3 release, 4 write fence, 5 full fence |
| stall | output | 1 | Request held this cycle |
| wr_issue | input | 1 | One write issued toward the cache/bus |
| wr_ack | input | 1 | One write fully acknowledged |
| rd_issue | input | 1 | One load issued |
| rd_done | input | 1 | One load returned |
| acq_done | input | 1 | Pending acquire has completed |
| rel_done | output | 1 | Pending release has completed (one-cycle pulse) |
| wr_cnt_err | output | 1 | Write counter overflow/underflow pulse |
| rd_cnt_err | output | 1 | Load counter overflow/underflow pulse |

## Verification
The bench builds the unit with CNT_W = 3, so full scale is 7. This lets it sweep every issue count from 0 up to one past saturation and release a waiting write fence one acknowledgement at a time. Each sweep walks the whole counter range, including the overflow and underflow edges. With the small width, the same-cycle issue/acknowledge case can be tried both at zero and at full scale. The acquire, full fence and release scenarios use a few outstanding accesses whose retirement order is chosen so that each completion condition is reached exactly once.

// File: rtl/fou_pkg.sv
`timescale 1ns/1ps
package fou_pkg;
  localparam int DEF_CNT_W = 6;
  localparam int NUM_CLS   = 2;   // class 0: writes, class 1: loads
  localparam int CLS_WR    = 0;
  localparam int CLS_RD    = 1;

  typedef enum logic [2:0] {
    KIND_LOAD   = 3'd0,
    KIND_STORE  = 3'd1,
    KIND_ACQ    = 3'd2,
    KIND_REL    = 3'd3,
    KIND_WFENCE = 3'd4,
    KIND_FFENCE = 3'd5
  } req_kind_e;
endpackage

// File: rtl/fou_sat_counter.sv
`timescale 1ns/1ps
module fou_sat_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic [W-1:0] count_nxt,
  output logic         err
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic err_nxt;

  always_comb begin
    count_nxt = count;
    err_nxt   = 1'b0;
    if (inc && !dec) begin
      if (count == TOP) err_nxt = 1'b1;
      else              count_nxt = count + ONE;
    end else if (dec && !inc) begin
      if (count == '0)  err_nxt = 1'b1;
      else              count_nxt = count - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      err   <= 1'b0;
    end else begin
      count <= count_nxt;
      err   <= err_nxt;
    end
  end
endmodule

// File: rtl/fou_release_tracker.sv
`timescale 1ns/1ps
module fou_release_tracker #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] wr_snap,
  input  logic [W-1:0] rd_snap,
  input  logic         wr_ack,
  input  logic         rd_done,
  output logic         pending,
  output logic         done
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] wr_left;
  logic [W-1:0] rd_left;

  assign done = pending && (wr_left == '0) && (rd_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      wr_left <= '0;
      rd_left <= '0;
    end else if (start) begin
      pending <= 1'b1;
      wr_left <= wr_snap;
      rd_left <= rd_snap;
    end else if (done) begin
      pending <= 1'b0;
    end else if (pending) begin
      if (wr_ack  && wr_left != '0) wr_left <= wr_left - ONE;
      if (rd_done && rd_left != '0) rd_left <= rd_left - ONE;
    end
  end
endmodule

// File: rtl/fou_order_gate.sv
`timescale 1ns/1ps
module fou_order_gate
  import fou_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  logic       wr_zero,
  input  logic       rd_zero,
  input  logic       rel_pend,
  input  logic       acq_done,
  output logic       stall,
  output logic       acq_pend,
  output logic       rel_start
);
  req_kind_e kind;
  logic      blocked;
  logic      accept;

  assign kind = req_kind_e'(req_kind);

  always_comb begin
    blocked = acq_pend;
    unique case (kind)
      KIND_WFENCE: if (!wr_zero)             blocked = 1'b1;
      KIND_FFENCE: if (!(wr_zero && rd_zero)) blocked = 1'b1;
      KIND_REL:    if (rel_pend)            blocked = 1'b1;
      default: ;
    endcase
  end

  assign stall     = req_valid && blocked;
  assign accept    = req_valid && !blocked;
  assign rel_start = accept && (kind == KIND_REL);

  always_ff @(posedge clk) begin
    if (!rst_n)                              acq_pend <= 1'b0;
    else if (accept && kind == KIND_ACQ)     acq_pend <= 1'b1;
    else if (acq_done)                       acq_pend <= 1'b0;
  end
endmodule

// File: rtl/fence_order_unit.sv
`timescale 1ns/1ps
module fence_order_unit
  import fou_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  output logic       stall,
  input  logic       wr_issue,
  input  logic       wr_ack,
  input  logic       rd_issue,
  input  logic       rd_done,
  input  logic       acq_done,
  output logic       rel_done,
  output logic       wr_cnt_err,
  output logic       rd_cnt_err
);
  logic [NUM_CLS-1:0] cls_inc, cls_dec, cls_err, cls_zero;
  logic [CNT_W-1:0]   cls_cnt [NUM_CLS];
  logic [CNT_W-1:0]   cls_nxt [NUM_CLS];

  assign cls_inc[CLS_WR] = wr_issue;
  assign cls_dec[CLS_WR] = wr_ack;
  assign cls_inc[CLS_RD] = rd_issue;
  assign cls_dec[CLS_RD] = rd_done;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    fou_sat_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (cls_inc[g]),
      .dec      (cls_dec[g]),
      .count    (cls_cnt[g]),
      .count_nxt(cls_nxt[g]),
      .err      (cls_err[g])
    );
    assign cls_zero[g] = (cls_cnt[g] == '0);
  end

  logic [CNT_W-1:0] wr_cnt, rd_cnt;
  logic             acq_pend, rel_pend, rel_start;

  assign wr_cnt     = cls_cnt[CLS_WR];
  assign rd_cnt     = cls_cnt[CLS_RD];
  assign wr_cnt_err = cls_err[CLS_WR];
  assign rd_cnt_err = cls_err[CLS_RD];

  fou_order_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .wr_zero  (cls_zero[CLS_WR]),
    .rd_zero  (cls_zero[CLS_RD]),
    .rel_pend (rel_pend),
    .acq_done (acq_done),
    .stall    (stall),
    .acq_pend (acq_pend),
    .rel_start(rel_start)
  );

  fou_release_tracker #(.W(CNT_W)) u_rel (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rel_start),
    .wr_snap(cls_nxt[CLS_WR]),
    .rd_snap(cls_nxt[CLS_RD]),
    .wr_ack (wr_ack),
    .rd_done(rd_done),
    .pending(rel_pend),
    .done   (rel_done)
  );
endmodule

// File: rtl/fence_order_unit_checker.sv
`timescale 1ns/1ps
module fence_order_unit_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_kind,
  input logic             stall,
  input logic             wr_issue,
  input logic             wr_ack,
  input logic [CNT_W-1:0] wr_cnt,
  input logic [CNT_W-1:0] rd_cnt,
  input logic             wr_cnt_err,
  input logic             acq_pend,
  input logic             rel_pend,
  input logic             rel_done
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_WR_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_issue && !wr_ack && wr_cnt != TOP) |=> (wr_cnt == $past(wr_cnt) + ONE)); // R1
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_issue && wr_ack) |=> ($stable(wr_cnt) && !wr_cnt_err)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_issue && !wr_ack && wr_cnt == TOP) |=> (wr_cnt_err && wr_cnt == TOP)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !wr_issue && wr_cnt == '0) |=> (wr_cnt_err && wr_cnt == '0)); // R4
  AST_WFENCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd4 && wr_cnt != '0) |-> stall); // R5
  AST_FFENCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd5 && (wr_cnt != '0 || rd_cnt != '0)) |-> stall); // R6
  AST_ACQ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !stall && req_kind == 3'd2) |=> (req_valid -> stall)); // R7
  AST_ACCESS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acq_pend && req_kind <= 3'd1) |-> !stall); // R8
  AST_REL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |=> !rel_done); // R9
  AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_pend && req_valid && req_kind == 3'd3) |-> stall); // R10
endmodule

bind fence_order_unit fence_order_unit_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .stall     (stall),
  .wr_issue  (wr_issue),
  .wr_ack    (wr_ack),
  .wr_cnt    (wr_cnt),
  .rd_cnt    (rd_cnt),
  .wr_cnt_err(wr_cnt_err),
  .acq_pend  (acq_pend),
  .rel_pend  (rel_pend),
  .rel_done  (rel_done)
);

// File: tb/fence_order_unit_tb_top.sv
`timescale 1ns/1ps
module fence_order_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 3;
  localparam int FULL       = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n, req_valid, wr_issue, wr_ack, rd_issue, rd_done, acq_done;
  logic [2:0] req_kind;
  logic stall, rel_done, wr_cnt_err, rd_cnt_err;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fence_order_unit #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .stall(stall), .wr_issue(wr_issue), .wr_ack(wr_ack), .rd_issue(rd_issue),
    .rd_done(rd_done), .acq_done(acq_done), .rel_done(rel_done),
    .wr_cnt_err(wr_cnt_err), .rd_cnt_err(rd_cnt_err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock edge; inputs stay as set, returns at next falling edge plus settle
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic present(input logic [2:0] k);
    req_valid = 1'b1;
    req_kind  = k;
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; wr_issue = 0; wr_ack = 0;
    rd_issue = 0; rd_done = 0; acq_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 stall", stall, 1'b0);
    chk("R11 rel_done", rel_done, 1'b0);
    chk("R11 wr_err", wr_cnt_err, 1'b0);
    chk("R11 rd_err", rd_cnt_err, 1'b0);
    present(3'd5);
    chk("R11 counts zero (full fence free)", stall, 1'b0);
    req_valid = 0;
    step();

    // sweep issue counts through saturation, release fence ack by ack
    for (int n = 0; n <= FULL + 1; n++) begin
      int eff;
      eff = (n > FULL) ? FULL : n;
      for (int i = 0; i < n; i++) begin
        wr_issue = 1; step(); wr_issue = 0; #1;
        chk("R3 overflow pulse", wr_cnt_err, (i >= FULL));
      end
      present(3'd4);
      chk("R5 fence with writes", stall, (eff != 0));
      for (int k = 1; k <= eff; k++) begin
        wr_ack = 1; step(); wr_ack = 0; #1;
        chk("R1 fence after ack", stall, (eff - k) != 0);
      end
      step();              // fence accepted
      req_valid = 0;
      wr_ack = 1; step(); wr_ack = 0; #1;
      chk("R4 underflow pulse", wr_cnt_err, 1'b1);
      step();
      chk("R4 pulse one cycle", wr_cnt_err, 1'b0);
      present(3'd4);
      chk("R4 count held at zero", stall, 1'b0);
      req_valid = 0;
      step();
    end

    // same-cycle issue and ack at zero and at full scale
    wr_issue = 1; wr_ack = 1; step(); wr_issue = 0; wr_ack = 0; #1;
    chk("R2 no error at zero", wr_cnt_err, 1'b0);
    present(3'd4);
    chk("R2 count stays zero", stall, 1'b0);
    req_valid = 0;
    for (int i = 0; i < FULL; i++) begin wr_issue = 1; step(); end
    wr_issue = 1; wr_ack = 1; step(); wr_issue = 0; wr_ack = 0; #1;
    chk("R2 no error at full", wr_cnt_err, 1'b0);
    for (int i = 0; i < FULL - 1; i++) begin wr_ack = 1; step(); end
    wr_ack = 0;
    present(3'd4);
    chk("R2 one write left", stall, 1'b1);
    req_valid = 0;
    wr_ack = 1; step(); wr_ack = 0;
    present(3'd4);
    chk("R2 drained", stall, 1'b0);
    req_valid = 0;
    step();

    // loads/stores free, full fence waits for both counters
    wr_issue = 1; rd_issue = 1; step(); wr_issue = 0; step(); rd_issue = 0;
    present(3'd0);
    chk("R8 load not held", stall, 1'b0);
    present(3'd1);
    chk("R8 store not held", stall, 1'b0);
    present(3'd5);
    chk("R6 full fence held", stall, 1'b1);
    req_valid = 0;
    wr_ack = 1; step(); wr_ack = 0;
    present(3'd5);
    chk("R6 loads still out", stall, 1'b1);
    present(3'd4);
    chk("R5 loads ignored by write fence", stall, 1'b0);
    req_valid = 0;
    rd_done = 1; step();
    present(3'd5);
    chk("R6 one load out", stall, 1'b1);
    req_valid = 0;
    step(); rd_done = 0;
    present(3'd5);
    chk("R6 all retired", stall, 1'b0);
    req_valid = 0;
    step();

    // acquire
    acq_done = 1; step(); acq_done = 0;
    present(3'd2);
    chk("R7 acquire accepted", stall, 1'b0);
    step();
    present(3'd0);
    chk("R7 load after acquire held", stall, 1'b1);
    step(); step();
    present(3'd1);
    chk("R7 store still held", stall, 1'b1);
    acq_done = 1; #1;
    chk("R7 held in pulse cycle", stall, 1'b1);
    step(); acq_done = 0; #1;
    chk("R7 free after acq_done", stall, 1'b0);
    step();
    req_valid = 0;

    // release
    wr_issue = 1; rd_issue = 1; step(); rd_issue = 0; step(); wr_issue = 0;
    present(3'd3);
    chk("R9 release not held", stall, 1'b0);
    chk("R9 not done yet", rel_done, 1'b0);
    step();
    chk("R9 not done after accept", rel_done, 1'b0);
    present(3'd3);
    chk("R10 second release held", stall, 1'b1);
    present(3'd1);
    chk("R9 later store proceeds", stall, 1'b0);
    wr_issue = 1; step(); wr_issue = 0; req_valid = 0; #1;
    wr_ack = 1; step(); #1;
    chk("R9 one write left", rel_done, 1'b0);
    step(); wr_ack = 0; #1;
    chk("R9 load left", rel_done, 1'b0);
    rd_done = 1; step(); rd_done = 0; #1;
    chk("R9 done with later write out", rel_done, 1'b1);
    step();
    chk("R9 pulse one cycle", rel_done, 1'b0);
    wr_ack = 1; step(); wr_ack = 0;
    present(3'd3);
    chk("R10 release free again", stall, 1'b0);
    step(); req_valid = 0; #1;
    chk("R9 immediate completion", rel_done, 1'b1);
    step();
    chk("R9 immediate pulse ends", rel_done, 1'b0);

    finished = 1'b1;
    summary();
  end
endmodule